// File: doc/BRIEF.md
# Address Translation Cache with Page-Table Walker

This block turns 32-bit virtual addresses into 30-bit physical addresses. It keeps recent page translations in a small fully associative buffer. A client presents a virtual address on a valid/ready request port. When the virtual page is already cached, the physical address comes back on the cycle after acceptance. When it is not cached, a built-in walker reads one 32-bit page-table entry from memory through a single-beat read port. The entry's address is formed from a base register and the virtual page number. A valid entry is installed in the buffer and the lookup is retried, so that it completes as a hit. An invalid entry ends the request with a page-fault flag and leaves the buffer unchanged.

The low 12 bits of an address are the page offset and pass through unchanged. Bits 31:12 are the 20-bit virtual page number, and an 18-bit physical page number replaces them. A flush input empties the buffer, and so does any write of the base register. A refill goes to the lowest-numbered free slot. When every slot is in use, a free-running LFSR picks the slot to overwrite.

Top module: `xlat_cache`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid and mem_rd_valid are 0, and no translation is cached, so the first request to any page starts a walk.
- R2: A request whose page is cached gives rsp_valid=1, rsp_fault=0 and rsp_paddr = {cached 18-bit page number, vaddr[11:0]} in the cycle after acceptance, with no memory read.
- R3: A request whose page is not cached raises mem_rd_valid for exactly one cycle, the cycle after acceptance. mem_rd_addr is the base register plus the virtual page number times 4, taken modulo 2^32.
- R4: When the read returns an entry with bit 31 set, the response arrives one cycle after mem_rd_data_valid. It has rsp_fault=0 and rsp_paddr = {entry bits 17:0, vaddr[11:0]}.
- R5: When the returned entry has bit 31 clear, the response arrives one cycle after mem_rd_data_valid with rsp_fault=1. The entry is not cached, so the same page walks again on its next request.
- R6: req_ready is 0 from the cycle after acceptance until the response cycle, and it is 1 again in the cycle that follows the response.
- R7: A one-cycle pulse on flush removes every cached translation.
- R8: A write to the base register removes every cached translation, and later walks use the new base.
- R9: A refill never displaces a valid entry while a free slot exists. With DEPTH or fewer distinct valid pages since the last flush, every repeat request hits.
- R10: When all slots are full, a refill overwrites one entry and the new translation hits at once. With more distinct valid pages than DEPTH, a rescan of those pages produces at least (pages − DEPTH) walks, and every result is still correct.
- R11: A flush or base write during an outstanding walk discards the entry that walk returns. The lookup is then retried, and it walks again from the new base.
- R12: mem_rd_data is ignored except in a cycle where mem_rd_data_valid is 1 while a walk is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ready | output | 1 | Block can accept a request |
| rsp_valid | output | 1 | Response present (one cycle) |
| rsp_paddr | output | 30 | Physical address, zero on a fault |
| rsp_fault | output | 1 | Page not present |
| flush | input | 1 | Remove every cached translation |
| ptr_we | input | 1 | Write the page-table base register |
| ptr_wdata | input | 32 | New page-table base |
| mem_rd_valid | output | 1 | One-cycle read request for a page-table entry |
| mem_rd_addr | output | 32 | Byte address of the entry |
| mem_rd_data_valid | input | 1 | Read data present |
| mem_rd_data | input | 32 | Entry: bit 31 valid, bits 17:0 page number |

## Verification
The hardest case to reach from the ports is a flush or base write that arrives while a walk is waiting on memory. The stimulus reaches it by pulsing a base write two cycles after acceptance, while the model memory is still counting down a latency that depends on the page. It then checks that a second read goes out to the new table and that the answer matches the new table. Replacement under a full buffer is the other hard case. A sweep first overfills the buffer with more distinct valid pages than it has slots and then rescans all of them. The check puts a lower bound on the walks, because the LFSR decides which entries survive.

// File: rtl/xlat_pkg.sv
// Shared widths and the controller state type for the address translation cache.
// Assumes 4 KiB pages, 32-bit virtual and 30-bit physical addresses.
package xlat_pkg;
    localparam int VA_W  = 32;
    localparam int OFF_W = 12;
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PPN_W = 18;
    localparam int PA_W  = PPN_W + OFF_W;
    localparam int PTE_VALID_BIT = 31;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_WAIT  = 2'd2,
        ST_FAULT = 2'd3
    } xlat_state_e;
endpackage

// File: rtl/xlat_cam.sv
// Fully associative store of page translations: every tag is compared with the
// lookup page number in parallel, and at most one entry is expected to match.
// Assumes that refills only happen after a miss, so tags never repeat.
module xlat_cam
    import xlat_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDXW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             hit,
    output logic [PPN_W-1:0] hit_ppn,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [IDXW-1:0]  wr_idx,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PPN_W-1:0] wr_ppn,
    output logic [DEPTH-1:0] valid_o
);
    logic [DEPTH-1:0] valid_q;
    logic [VPN_W-1:0] tag_q [DEPTH];
    logic [PPN_W-1:0] ppn_q [DEPTH];
    logic [DEPTH-1:0] match;

    // Valid bits: clear wins over a refill in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)     valid_q <= '0;
        else if (clr)   valid_q <= '0;
        else if (wr_en) valid_q[wr_idx] <= 1'b1;
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_ent
            // Entry payload: loaded on a refill into this slot.
            always_ff @(posedge clk) begin
                if (wr_en && wr_idx == IDXW'(g)) begin
                    tag_q[g] <= wr_vpn;
                    ppn_q[g] <= wr_ppn;
                end
            end
            assign match[g] = valid_q[g] && (tag_q[g] == lk_vpn);
        end
    endgenerate

    // Merge the matching entry's page number (one-hot select by OR).
    always_comb begin
        hit_ppn = '0;
        for (int i = 0; i < DEPTH; i++)
            if (match[i]) hit_ppn = hit_ppn | ppn_q[i];
    end

    assign hit     = |match;
    assign valid_o = valid_q;

    // R7
    clr_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (valid_q == '0));

    // R9
    single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
endmodule

// File: rtl/xlat_victim.sv
// Chooses the slot for the next refill: the lowest free slot if any, else a
// pseudo-random slot from a 16-bit Galois LFSR that steps every cycle.
// Assumes DEPTH is a power of two no larger than 2^16.
module xlat_victim #(
    parameter int DEPTH = 16,
    localparam int IDXW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEPTH-1:0] valid_i,
    output logic [IDXW-1:0]  victim_idx
);
    logic [15:0]     lfsr_q;
    logic [IDXW-1:0] free_idx;
    logic            any_free;

    // LFSR: free-running pseudo-random source.
    always_ff @(posedge clk) begin
        if (!rst_n) lfsr_q <= 16'hACE1;
        else        lfsr_q <= {1'b0, lfsr_q[15:1]} ^ (lfsr_q[0] ? 16'hB400 : 16'h0000);
    end

    // Priority search for the lowest-numbered free slot.
    always_comb begin
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--)
            if (!valid_i[i]) free_idx = IDXW'(i);
    end

    assign any_free   = ~&valid_i;
    assign victim_idx = any_free ? free_idx : lfsr_q[IDXW-1:0];

    // R9
    free_slot_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_free |-> !valid_i[victim_idx]);
endmodule

// File: rtl/xlat_cache.sv
// Address translation cache with a single-level page-table walker.
// A request is looked up the cycle after acceptance; a miss issues one read of
// base + vpn*4, installs a valid entry and retries, or reports a fault.
// Assumes the memory returns exactly one data beat per read request.
module xlat_cache
    import xlat_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [31:0] req_vaddr,
    output logic        req_ready,
    output logic        rsp_valid,
    output logic [29:0] rsp_paddr,
    output logic        rsp_fault,
    input  logic        flush,
    input  logic        ptr_we,
    input  logic [31:0] ptr_wdata,
    output logic        mem_rd_valid,
    output logic [31:0] mem_rd_addr,
    input  logic        mem_rd_data_valid,
    input  logic [31:0] mem_rd_data
);
    localparam int IDXW = $clog2(DEPTH);

    xlat_state_e      state_q, state_d;
    logic [VA_W-1:0]  vaddr_q;
    logic [31:0]      ptr_q;
    logic             stale_q;
    logic             clr, accept, hit, fill, stale_now, pte_ok;
    logic [PPN_W-1:0] hit_ppn;
    logic [DEPTH-1:0] valid_vec;
    logic [IDXW-1:0]  victim_idx;
    logic [VPN_W-1:0] cur_vpn;

    assign clr       = flush | ptr_we;
    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid & req_ready;
    assign cur_vpn   = vaddr_q[VA_W-1:OFF_W];
    assign pte_ok    = mem_rd_data[PTE_VALID_BIT];
    assign stale_now = stale_q | clr;
    assign fill      = (state_q == ST_WAIT) && mem_rd_data_valid && pte_ok && !stale_now;

    xlat_cam #(.DEPTH(DEPTH)) i_cam (
        .clk     (clk),
        .rst_n   (rst_n),
        .lk_vpn  (cur_vpn),
        .hit     (hit),
        .hit_ppn (hit_ppn),
        .clr     (clr),
        .wr_en   (fill),
        .wr_idx  (victim_idx),
        .wr_vpn  (cur_vpn),
        .wr_ppn  (mem_rd_data[PPN_W-1:0]),
        .valid_o (valid_vec)
    );

    xlat_victim #(.DEPTH(DEPTH)) i_victim (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_i    (valid_vec),
        .victim_idx (victim_idx)
    );

    // Next-state logic of the request / walk controller.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_CHECK;
            ST_CHECK: state_d = hit ? ST_IDLE : ST_WAIT;
            ST_WAIT:  if (mem_rd_data_valid)
                          state_d = (pte_ok || stale_now) ? ST_CHECK : ST_FAULT;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Controller state, request capture and base register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            vaddr_q <= '0;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) vaddr_q <= req_vaddr;
            if (ptr_we) ptr_q   <= ptr_wdata;
        end
    end

    // Marks an outstanding walk whose result predates a flush or base write.
    always_ff @(posedge clk) begin
        if (!rst_n)                    stale_q <= 1'b0;
        else if (state_q == ST_CHECK)  stale_q <= clr;
        else if (state_q == ST_WAIT)   stale_q <= stale_q | clr;
        else                           stale_q <= 1'b0;
    end

    assign mem_rd_valid = (state_q == ST_CHECK) && !hit;
    assign mem_rd_addr  = ptr_q + {10'b0, cur_vpn, 2'b00};
    assign rsp_valid    = ((state_q == ST_CHECK) && hit) || (state_q == ST_FAULT);
    assign rsp_fault    = (state_q == ST_FAULT);
    assign rsp_paddr    = ((state_q == ST_CHECK) && hit) ? {hit_ppn, vaddr_q[OFF_W-1:0]} : '0;

    // R6
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R6
    idle_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> req_ready);

    // R2
    hit_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> !mem_rd_valid);

    // R3
    fetch_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |=> !mem_rd_valid);

    // R5
    fault_no_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> $stable(valid_vec) || (valid_vec == '0));
endmodule

// File: tb/test_xlat_cache.sv
// Self-checking bench: model page table computed arithmetically from the base,
// page-dependent memory latency, sweeps over fills, refills, faults and flushes.
module test_xlat_cache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_ready;
    logic        rsp_valid;
    logic [29:0] rsp_paddr;
    logic        rsp_fault;
    logic        flush = 1'b0;
    logic        ptr_we = 1'b0;
    logic [31:0] ptr_wdata = '0;
    logic        mem_rd_valid;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_data_valid;
    logic [31:0] mem_rd_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [31:0] cur_base = '0;
    int          mcnt = 0;
    logic [31:0] mdata = '0;

    always #2 clk = ~clk;

    xlat_cache #(.DEPTH(16)) i_xlat_cache (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_fault(rsp_fault), .flush(flush), .ptr_we(ptr_we), .ptr_wdata(ptr_wdata),
        .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data_valid(mem_rd_data_valid), .mem_rd_data(mem_rd_data)
    );

    function automatic bit pg_ok(input logic [19:0] vpn);
        return (vpn % 5) != 3;
    endfunction

    function automatic logic [17:0] pg_ppn(input logic [19:0] vpn, input logic [31:0] b);
        return 18'((vpn * 37 + b[27:20]) & 18'h3FFFF);
    endfunction

    function automatic logic [31:0] va_of(input logic [19:0] vpn);
        return {vpn, 12'((vpn * 291) & 12'hFFF)};
    endfunction

    // Memory model: data appears (1 + vpn%4) cycles after the request pulse.
    always @(posedge clk) begin
        if (!rst_n) mcnt <= 0;
        else if (mem_rd_valid) begin
            mcnt  <= 1 + int'(((mem_rd_addr - cur_base) >> 2) % 4);
            mdata <= {pg_ok(20'((mem_rd_addr - cur_base) >> 2)), 13'b0,
                      pg_ppn(20'((mem_rd_addr - cur_base) >> 2), cur_base)};
        end else if (mcnt != 0) mcnt <= mcnt - 1;
    end
    assign mem_rd_data_valid = (mcnt == 1);
    assign mem_rd_data       = (mcnt == 1) ? mdata : 32'hFFFF_FFFF;

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic set_base(input logic [31:0] b);
        @(negedge clk); ptr_we = 1'b1; ptr_wdata = b; cur_base = b;
        @(negedge clk); ptr_we = 1'b0;
    endtask

    task automatic xlat(input logic [31:0] va, input bit poke, input logic [31:0] nb,
                        output logic [29:0] pa, output bit flt, output int walks,
                        output int cyc, output logic [31:0] maddr);
        walks = 0; cyc = 0; pa = '0; flt = 1'b0; maddr = '0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R6 ready while idle", 32'(req_ready), 1);
        req_valid = 1'b1; req_vaddr = va;
        @(negedge clk);
        req_valid = 1'b0; cyc = 1;
        forever begin
            if (mem_rd_valid) begin walks++; maddr = mem_rd_addr; end
            if (rsp_valid) begin pa = rsp_paddr; flt = rsp_fault; break; end
            if (req_ready) chk(1'b0, "R6 ready before response", 1, 0);
            ptr_we = poke && (cyc == 2);
            if (ptr_we) begin ptr_wdata = nb; cur_base = nb; end
            @(negedge clk);
            ptr_we = 1'b0;
            cyc++;
            if (cyc > 200) begin chk(1'b0, "R4 response timeout", 32'(cyc), 0); break; end
        end
        ptr_we = 1'b0;
    endtask

    // Watchdog: a hung run is a failed check and still prints the summary.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++; checks++;
                $display("FAIL watchdog R6: actual %0d cycles expected below 150000", cycles);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [29:0] pa;
        logic [31:0] ma;
        bit          flt;
        int          w, c, miss_cnt;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1 req_ready after reset", 32'(req_ready), 1);
        chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", 32'(rsp_valid), 0);
        chk(mem_rd_valid == 1'b0, "R1 mem_rd_valid after reset", 32'(mem_rd_valid), 0);

        set_base(32'h0010_0000);
        // First touch of pages 0..15: every one walks (R1, R3, R4, R5).
        for (int v = 0; v < 16; v++) begin
            xlat(va_of(20'(v)), 1'b0, 32'h0, pa, flt, w, c, ma);
            chk(w == 1, "R1 first access walks", 32'(w), 1);
            chk(ma == cur_base + 32'(v) * 4, "R3 entry address", ma, cur_base + 32'(v) * 4);
            chk(c == 3 + v % 4, "R4 walk latency", 32'(c), 32'(3 + v % 4));
            chk(flt == !pg_ok(20'(v)), "R5 fault flag", 32'(flt), 32'(!pg_ok(20'(v))));
            if (pg_ok(20'(v)))
                chk(pa == {pg_ppn(20'(v), cur_base), va_of(20'(v))[11:0]}, "R4 refilled address",
                    32'(pa), 32'({pg_ppn(20'(v), cur_base), va_of(20'(v))[11:0]}));
            else
                chk(pa == '0, "R5 fault address zero", 32'(pa), 0);
        end
        // Repeat pages 0..15: valid ones hit in one cycle (R2, R9), faults walk again (R5).
        for (int v = 0; v < 16; v++) begin
            xlat(va_of(20'(v)), 1'b0, 32'h0, pa, flt, w, c, ma);
            if (pg_ok(20'(v))) begin
                chk(w == 0 && c == 1, "R9 no eviction while free / R2 hit timing", 32'(c), 1);
                chk(pa == {pg_ppn(20'(v), cur_base), va_of(20'(v))[11:0]} && !flt, "R2 hit address",
                    32'(pa), 32'({pg_ppn(20'(v), cur_base), va_of(20'(v))[11:0]}));
            end else
                chk(w == 1 && flt, "R5 faulting page not cached", 32'(w), 1);
        end
        // Overfill: pages 16..22, newest entry hits at once (R10).
        for (int v = 16; v < 23; v++) begin
            xlat(va_of(20'(v)), 1'b0, 32'h0, pa, flt, w, c, ma);
            chk(flt == !pg_ok(20'(v)), "R10 fill beyond depth fault flag", 32'(flt), 32'(!pg_ok(20'(v))));
            if (pg_ok(20'(v))) begin
                xlat(va_of(20'(v)), 1'b0, 32'h0, pa, flt, w, c, ma);
                chk(w == 0 && pa == {pg_ppn(20'(v), cur_base), va_of(20'(v))[11:0]},
                    "R10 new entry hits", 32'(pa), 32'({pg_ppn(20'(v), cur_base), va_of(20'(v))[11:0]}));
            end
        end
        // Rescan 19 valid pages over 16 slots: at least 3 walks, all correct (R10).
        miss_cnt = 0;
        for (int v = 0; v < 23; v++) begin
            if (!pg_ok(20'(v))) continue;
            xlat(va_of(20'(v)), 1'b0, 32'h0, pa, flt, w, c, ma);
            miss_cnt += w;
            chk(!flt && pa == {pg_ppn(20'(v), cur_base), va_of(20'(v))[11:0]}, "R10 rescan address",
                32'(pa), 32'({pg_ppn(20'(v), cur_base), va_of(20'(v))[11:0]}));
        end
        chk(miss_cnt >= 3, "R10 rescan walk count", 32'(miss_cnt), 3);

        // R7 flush empties the buffer.
        xlat(va_of(20'd22), 1'b0, 32'h0, pa, flt, w, c, ma);
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        xlat(va_of(20'd22), 1'b0, 32'h0, pa, flt, w, c, ma);
        chk(w == 1, "R7 walk after flush", 32'(w), 1);

        // R8 base write flushes and redirects walks.
        set_base(32'h0200_0000);
        xlat(va_of(20'd22), 1'b0, 32'h0, pa, flt, w, c, ma);
        chk(w == 1 && ma == 32'h0200_0058, "R8 walk from new base", ma, 32'h0200_0058);
        chk(pa == {pg_ppn(20'd22, cur_base), va_of(20'd22)[11:0]}, "R8 new translation",
            32'(pa), 32'({pg_ppn(20'd22, cur_base), va_of(20'd22)[11:0]}));

        // R11 base write during an outstanding walk: result discarded, walk repeated.
        for (int v = 4; v < 8; v++) begin
            if (!pg_ok(20'(v))) continue;
            xlat(va_of(20'(v)), 1'b1, 32'h0300_0000 + 32'(v) * 32'h0010_0000, pa, flt, w, c, ma);
            chk(w == 2, "R11 second walk", 32'(w), 2);
            chk(ma == cur_base + 32'(v) * 4, "R11 second walk address", ma, cur_base + 32'(v) * 4);
            chk(!flt && pa == {pg_ppn(20'(v), cur_base), va_of(20'(v))[11:0]}, "R11 translation from new base",
                32'(pa), 32'({pg_ppn(20'(v), cur_base), va_of(20'(v))[11:0]}));
            xlat(va_of(20'(v)), 1'b0, 32'h0, pa, flt, w, c, ma);
            chk(w == 0, "R11 retried entry cached", 32'(w), 0);
        end

        // R3 address wraps modulo 2^32; R12 garbage data outside the valid beat ignored.
        set_base(32'hFFC0_0000);
        xlat({20'hFFFFF, 12'hFFF}, 1'b0, 32'h0, pa, flt, w, c, ma);
        chk(ma == 32'hFFFF_FFFC, "R3 wrapped entry address", ma, 32'hFFFF_FFFC);
        chk(pa == {pg_ppn(20'hFFFFF, cur_base), 12'hFFF}, "R12 only valid beat used",
            32'(pa), 32'({pg_ppn(20'hFFFFF, cur_base), 12'hFFF}));
        xlat({20'hFFFFF, 12'h000}, 1'b0, 32'h0, pa, flt, w, c, ma);
        chk(w == 0 && pa == {pg_ppn(20'hFFFFF, cur_base), 12'h000}, "R2 offset zero hit",
            32'(pa), 32'({pg_ppn(20'hFFFFF, cur_base), 12'h000}));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule